// File: doc/BRIEF.md
# Early Branch Resolution Unit

This unit sits in the decode/register-read stage of a five-stage in-order pipeline. It settles conditional branches and unconditional jumps one stage after fetch, so a taken control transfer wastes only one fetch slot. A conditional branch tests a single register against zero. The register value arrives through the forwarding network. A dedicated adder in decode forms the branch target from the sequential PC and the word-scaled signed offset. A jump takes its target from the instruction's 26-bit index, joined with the upper PC bits.

The unit is purely combinational. It tells the fetch stage where the next PC comes from and what the redirect address is. On a redirect it raises a flush that clears the fetch/decode register, which turns the wrongly fetched instruction into a no-op. The branch register may still be in flight: an ALU result in execute, or a load in execute or memory. In that case the unit holds the PC and asks the pipeline to stall decode until forwarding can supply the value.

Top module: `ebr_unit`

## Requirements
- R1: A branch-if-zero instruction has opcode 6'h04 in bits 31:26. When no stall applies, it is taken exactly when the forwarded register value equals zero. Taken means pc_sel = 2'd1 (redirect) and flush_ifid = 1.
- R2: A branch-if-nonzero instruction has opcode 6'h05. When no stall applies, it is taken exactly when the forwarded register value is not zero. It gives the same redirect and flush outputs as R1.
- R3: Several cases give pc_sel = 2'd0 (sequential), flush_ifid = 0 and stall_id = 0: any opcode other than 6'h02, 6'h04 and 6'h05 (the all-zero no-op included), and any branch that is not taken.
- R4: The branch target on redirect_pc is id_pc_plus4 plus the sign-extended bits 15:0, shifted left by two, taken modulo 2^32. Negative offsets and address wrap follow the same rule.
- R5: A jump (opcode 6'h02) always gives pc_sel = 2'd1 and flush_ifid = 1, and never stalls, whatever the register value or hazard inputs. Its redirect_pc is {id_pc_plus4[31:28], id_instr[25:0], 2'b00}.
- R6: A branch stalls when its tested register (bits 25:21) is nonzero and equals ex_rd while ex_wr_en = 1. A stall gives stall_id = 1, pc_sel = 2'd2 (hold) and flush_ifid = 0, whatever the register value.
- R7: A branch also stalls, with the same outputs as R6, when its nonzero tested register equals mem_rd while mem_ld = 1.
- R8: None of the following stalls: a branch that tests register 0, a match against mem_rd when mem_ld = 0, or a match against ex_rd when ex_wr_en = 0. Such a branch resolves by R1 or R2.
- R9: flush_ifid is high exactly when pc_sel is 2'd1. Flush and stall are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_instr | input | 32 | Instruction held in the fetch/decode register |
| id_pc_plus4 | input | 32 | Sequential PC of that instruction (its address plus 4) |
| id_rs_val | input | 32 | Forwarded value of the tested register |
| ex_wr_en | input | 1 | Instruction in execute writes a register (ALU or load) |
| ex_rd | input | 5 | Destination register of the instruction in execute |
| mem_ld | input | 1 | Instruction in memory stage is a load |
| mem_rd | input | 5 | Destination register of the load in memory stage |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 redirect, 2 hold |
| redirect_pc | output | 32 | Redirect address, meaningful when pc_sel is 1 |
| flush_ifid | output | 1 | Clear the fetch/decode register to a no-op |
| stall_id | output | 1 | Hold decode and insert a bubble downstream |

## Verification
Two functions can fall in the same cycle: branch resolution and the in-flight hazard stall. A branch can see a register value that would make it taken while the true value is still being produced upstream. The bench provokes this by showing a zero value to a branch-if-zero while execute, or a load in memory, targets the same register. The stall must win, with hold, no flush and stall high. When the hazard inputs are then released in the next step, the same branch must redirect with the correct target. A jump presented under a matching hazard checks that only branches are held.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

  localparam int unsigned INSN_W   = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned OPC_LSB  = 26;
  localparam int unsigned RS_LSB   = 21;
  localparam int unsigned RADDR_W  = 5;
  localparam int unsigned OFS_W    = 16;
  localparam int unsigned JIDX_W   = 26;

  localparam logic [OPC_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQZ = 6'h04;
  localparam logic [OPC_W-1:0] OPC_BNEZ = 6'h05;

  typedef enum logic [1:0] {
    NPC_SEQ   = 2'd0,
    NPC_REDIR = 2'd1,
    NPC_HOLD  = 2'd2
  } npc_sel_e;

endpackage

// File: rtl/ebr_decode.sv
module ebr_decode
  import ebr_pkg::*;
(
  input  logic [INSN_W-1:0]  insn,
  output logic               is_bz,
  output logic               is_bnz,
  output logic               is_jmp,
  output logic [RADDR_W-1:0] rs,
  output logic [OFS_W-1:0]   ofs,
  output logic [JIDX_W-1:0]  jidx
);

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc    = insn[OPC_LSB +: OPC_W];
    rs     = insn[RS_LSB +: RADDR_W];
    ofs    = insn[OFS_W-1:0];
    jidx   = insn[JIDX_W-1:0];
    is_bz  = (opc == OPC_BEQZ);
    is_bnz = (opc == OPC_BNEZ);
    is_jmp = (opc == OPC_JMP);
  end

endmodule

// File: rtl/ebr_zero_det.sv
module ebr_zero_det #(
  parameter int unsigned W     = 32,
  parameter int unsigned GROUP = 4
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);

  localparam int unsigned NG = (W + GROUP - 1) / GROUP;
  localparam int unsigned PW = NG * GROUP;

  logic [PW-1:0] padded;
  logic [NG-1:0] grp_any;

  assign padded = PW'(val);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign is_zero = ~(|grp_any);

endmodule

// File: rtl/ebr_hazard.sv
module ebr_hazard #(
  parameter int unsigned RAW = 5
) (
  input  logic           uses_rs,
  input  logic [RAW-1:0] rs,
  input  logic           ex_wr_en,
  input  logic [RAW-1:0] ex_rd,
  input  logic           mem_ld,
  input  logic [RAW-1:0] mem_rd,
  output logic           stall
);

  logic rs_live;
  logic hit_ex;
  logic hit_mem;

  always_comb begin
    rs_live = uses_rs && (rs != '0);
    hit_ex  = ex_wr_en && (ex_rd == rs);
    hit_mem = mem_ld && (mem_rd == rs);
    stall   = rs_live && (hit_ex || hit_mem);
  end

endmodule

// File: rtl/ebr_target.sv
module ebr_target #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned OFSW = 16,
  parameter int unsigned JW   = 26
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [OFSW-1:0] ofs,
  input  logic [JW-1:0]   jidx,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jmp_tgt
);

  localparam int unsigned EXT_W = XLEN - OFSW - 2;
  localparam int unsigned HI_W  = XLEN - JW - 2;

  logic [XLEN-1:0] ofs_scaled;

  always_comb begin
    ofs_scaled = {{EXT_W{ofs[OFSW-1]}}, ofs, 2'b00};
    br_tgt     = pc_plus4 + ofs_scaled;
    jmp_tgt    = {pc_plus4[XLEN-1 -: HI_W], jidx, 2'b00};
  end

endmodule

// File: rtl/ebr_unit.sv
module ebr_unit
  import ebr_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned ZT_GROUP = 4
) (
  input  logic [INSN_W-1:0]  id_instr,
  input  logic [XLEN-1:0]    id_pc_plus4,
  input  logic [XLEN-1:0]    id_rs_val,
  input  logic               ex_wr_en,
  input  logic [RADDR_W-1:0] ex_rd,
  input  logic               mem_ld,
  input  logic [RADDR_W-1:0] mem_rd,
  output logic [1:0]         pc_sel,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               flush_ifid,
  output logic               stall_id
);

  logic               is_bz;
  logic               is_bnz;
  logic               is_jmp;
  logic               is_br;
  logic [RADDR_W-1:0] rs;
  logic [OFS_W-1:0]   ofs;
  logic [JIDX_W-1:0]  jidx;
  logic               val_zero;
  logic               hz_stall;
  logic               br_taken;
  logic [XLEN-1:0]    br_tgt;
  logic [XLEN-1:0]    jmp_tgt;
  npc_sel_e           sel;

  ebr_decode u_dec (
    .insn   (id_instr),
    .is_bz  (is_bz),
    .is_bnz (is_bnz),
    .is_jmp (is_jmp),
    .rs     (rs),
    .ofs    (ofs),
    .jidx   (jidx)
  );

  ebr_zero_det #(.W(XLEN), .GROUP(ZT_GROUP)) u_zdet (
    .val     (id_rs_val),
    .is_zero (val_zero)
  );

  ebr_hazard #(.RAW(RADDR_W)) u_hz (
    .uses_rs  (is_br),
    .rs       (rs),
    .ex_wr_en (ex_wr_en),
    .ex_rd    (ex_rd),
    .mem_ld   (mem_ld),
    .mem_rd   (mem_rd),
    .stall    (hz_stall)
  );

  ebr_target #(.XLEN(XLEN), .OFSW(OFS_W), .JW(JIDX_W)) u_tgt (
    .pc_plus4 (id_pc_plus4),
    .ofs      (ofs),
    .jidx     (jidx),
    .br_tgt   (br_tgt),
    .jmp_tgt  (jmp_tgt)
  );

  always_comb begin
    is_br    = is_bz || is_bnz;
    br_taken = (is_bz && val_zero) || (is_bnz && !val_zero);
    sel         = NPC_SEQ;
    redirect_pc = br_tgt;
    if (is_jmp) begin
      sel         = NPC_REDIR;
      redirect_pc = jmp_tgt;
    end else if (is_br) begin
      if (hz_stall) begin
        sel = NPC_HOLD;
      end else if (br_taken) begin
        sel = NPC_REDIR;
      end
    end
  end

  assign pc_sel     = sel;
  assign flush_ifid = (sel == NPC_REDIR);
  assign stall_id   = (sel == NPC_HOLD);

endmodule

// File: rtl/ebr_unit_chk.sv
module ebr_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic [31:0]     id_instr,
  input logic [XLEN-1:0] id_pc_plus4,
  input logic            ex_wr_en,
  input logic [4:0]      ex_rd,
  input logic            mem_ld,
  input logic [4:0]      mem_rd,
  input logic [1:0]      pc_sel,
  input logic [XLEN-1:0] redirect_pc,
  input logic            flush_ifid,
  input logic            stall_id
);

  logic [5:0] opc;
  logic [4:0] rs;
  logic       is_branch;

  always_comb begin
    opc       = id_instr[31:26];
    rs        = id_instr[25:21];
    is_branch = (opc == 6'h04) || (opc == 6'h05);

    p_flush_redir_r9: assert (flush_ifid == (pc_sel == 2'd1))
      else $error("flush and redirect disagree");
    p_no_flush_stall_r9: assert (!(flush_ifid && stall_id))
      else $error("flush with stall");
    if (opc == 6'h02) begin
      p_jump_redir_r5: assert (pc_sel == 2'd1 && !stall_id &&
                               redirect_pc[1:0] == 2'b00 &&
                               redirect_pc[XLEN-1:XLEN-4] == id_pc_plus4[XLEN-1:XLEN-4])
        else $error("jump not redirected");
    end
    if (!is_branch && opc != 6'h02) begin
      p_other_seq_r3: assert (pc_sel == 2'd0 && !stall_id)
        else $error("non-control opcode changed flow");
    end
    if (is_branch && rs != 5'd0 && ex_wr_en && ex_rd == rs) begin
      p_ex_hazard_hold_r6: assert (stall_id && pc_sel == 2'd2)
        else $error("execute hazard not held");
    end
    if (is_branch && rs != 5'd0 && mem_ld && mem_rd == rs) begin
      p_mem_hazard_hold_r7: assert (stall_id && pc_sel == 2'd2)
        else $error("memory load hazard not held");
    end
    if (is_branch && pc_sel == 2'd1) begin
      p_br_align_r4: assert (redirect_pc[1:0] == id_pc_plus4[1:0])
        else $error("branch target misaligned");
    end
  end

endmodule

bind ebr_unit ebr_unit_chk #(.XLEN(XLEN)) u_chk (
  .id_instr    (id_instr),
  .id_pc_plus4 (id_pc_plus4),
  .ex_wr_en    (ex_wr_en),
  .ex_rd       (ex_rd),
  .mem_ld      (mem_ld),
  .mem_rd      (mem_rd),
  .pc_sel      (pc_sel),
  .redirect_pc (redirect_pc),
  .flush_ifid  (flush_ifid),
  .stall_id    (stall_id)
);

// File: tb/ebr_unit_tb.sv
module ebr_unit_tb;

  logic        clk;
  logic [31:0] id_instr;
  logic [31:0] id_pc_plus4;
  logic [31:0] id_rs_val;
  logic        ex_wr_en;
  logic [4:0]  ex_rd;
  logic        mem_ld;
  logic [4:0]  mem_rd;
  logic [1:0]  pc_sel;
  logic [31:0] redirect_pc;
  logic        flush_ifid;
  logic        stall_id;

  int n_chk;
  int n_fail;

  ebr_unit u_dut (
    .id_instr    (id_instr),
    .id_pc_plus4 (id_pc_plus4),
    .id_rs_val   (id_rs_val),
    .ex_wr_en    (ex_wr_en),
    .ex_rd       (ex_rd),
    .mem_ld      (mem_ld),
    .mem_rd      (mem_rd),
    .pc_sel      (pc_sel),
    .redirect_pc (redirect_pc),
    .flush_ifid  (flush_ifid),
    .stall_id    (stall_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] r,
                                      input logic [15:0] ofs);
    return {op, r, 5'd0, ofs};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] pc4, input logic [31:0] v,
                       input logic exw, input logic [4:0] exr,
                       input logic mld, input logic [4:0] mr);
    @(negedge clk);
    id_instr = ins; id_pc_plus4 = pc4; id_rs_val = v;
    ex_wr_en = exw; ex_rd = exr; mem_ld = mld; mem_rd = mr;
    #2;
  endtask

  task automatic expect_flow(input string req, input logic [1:0] sel,
                             input logic fl, input logic st);
    check({req, " pc_sel"}, {30'd0, pc_sel}, {30'd0, sel});
    check({req, " flush"}, {31'd0, flush_ifid}, {31'd0, fl});
    check({req, " stall"}, {31'd0, stall_id}, {31'd0, st});
  endtask

  task automatic t_idle();
    apply(32'h0, 32'h0000_1000, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R3 idle nop", 2'd0, 1'b0, 1'b0);
    apply(32'h2000_0000 | enc(6'h08, 5'd3, 16'h0010), 32'h0000_1000, 32'h0,
          1'b1, 5'd3, 1'b1, 5'd3);
    expect_flow("R3 other opcode", 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_beqz();
    apply(enc(6'h04, 5'd7, 16'h0004), 32'h0000_2000, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R1 beqz taken", 2'd1, 1'b1, 1'b0);
    check("R4 fwd target", redirect_pc, 32'h0000_2010);
    apply(enc(6'h04, 5'd7, 16'h0004), 32'h0000_2000, 32'h8000_0000, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R1 R3 beqz not taken", 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_bnez();
    apply(enc(6'h05, 5'd9, 16'h0002), 32'h0000_3000, 32'h0000_0001, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R2 bnez taken", 2'd1, 1'b1, 1'b0);
    check("R4 bnez target", redirect_pc, 32'h0000_3008);
    apply(enc(6'h05, 5'd9, 16'h0002), 32'h0000_3000, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R2 bnez not taken", 2'd0, 1'b0, 1'b0);
  endtask

  task automatic t_target();
    apply(enc(6'h04, 5'd1, 16'hFFFC), 32'h0000_1000, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    check("R4 negative offset", redirect_pc, 32'h0000_0FF0);
    apply(enc(6'h04, 5'd1, 16'h0008), 32'hFFFF_FFF0, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    check("R4 wrap", redirect_pc, 32'h0000_0010);
    apply(enc(6'h05, 5'd1, 16'h8000), 32'h0004_0000, 32'h5, 1'b0, 5'd0, 1'b0, 5'd0);
    check("R4 most negative", redirect_pc, 32'h0002_0000);
  endtask

  task automatic t_jump();
    apply({6'h02, 26'h123_4567}, 32'hA000_0004, 32'h0, 1'b1, 5'd0, 1'b1, 5'd0);
    expect_flow("R5 jump", 2'd1, 1'b1, 1'b0);
    check("R5 jump target", redirect_pc, {4'hA, 26'h123_4567, 2'b00});
    apply({6'h02, 5'd4, 21'h0_0100}, 32'h5000_0000, 32'h1, 1'b1, 5'd4, 1'b1, 5'd4);
    expect_flow("R5 jump under hazard", 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_stall_vs_resolve();
    apply(enc(6'h04, 5'd6, 16'h0001), 32'h0000_4000, 32'h0, 1'b1, 5'd6, 1'b0, 5'd0);
    expect_flow("R6 R9 ex hazard holds", 2'd2, 1'b0, 1'b1);
    apply(enc(6'h04, 5'd6, 16'h0001), 32'h0000_4000, 32'h0, 1'b0, 5'd0, 1'b0, 5'd0);
    expect_flow("R6 released resolves", 2'd1, 1'b1, 1'b0);
    check("R4 after release", redirect_pc, 32'h0000_4004);
    apply(enc(6'h05, 5'd12, 16'h0001), 32'h0000_4000, 32'h7, 1'b0, 5'd0, 1'b1, 5'd12);
    expect_flow("R7 mem load holds", 2'd2, 1'b0, 1'b1);
  endtask

  task automatic t_no_stall();
    apply(enc(6'h04, 5'd0, 16'h0003), 32'h0000_5000, 32'h0, 1'b1, 5'd0, 1'b1, 5'd0);
    expect_flow("R8 register zero", 2'd1, 1'b1, 1'b0);
    apply(enc(6'h05, 5'd12, 16'h0001), 32'h0000_5000, 32'h7, 1'b0, 5'd12, 1'b0, 5'd12);
    expect_flow("R8 non-writers", 2'd1, 1'b1, 1'b0);
    apply(enc(6'h04, 5'd12, 16'h0001), 32'h0000_5000, 32'h0, 1'b1, 5'd13, 1'b1, 5'd11);
    expect_flow("R8 other regs", 2'd1, 1'b1, 1'b0);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    id_instr = '0; id_pc_plus4 = '0; id_rs_val = '0;
    ex_wr_en = 1'b0; ex_rd = '0; mem_ld = 1'b0; mem_rd = '0;
    t_idle();
    t_beqz();
    t_bnez();
    t_target();
    t_jump();
    t_stall_vs_resolve();
    t_no_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule